// File: doc/BRIEF.md
# Event Interrupt Pulse Generator

This block watches a set of status event inputs, such as an output-driver overcurrent or an overflow in the processing filters. It records each new event in a sticky flag register and raises two independent interrupt lines towards a host. Each line has its own event-enable mask and its own output mode. In single mode, every enabled event produces one pulse of fixed width. In train mode, the line toggles with a fixed period until the host reads the flag register.

Event inputs are synchronous levels, and only a rising edge counts as an event. The host reads the flags by pulsing `flag_rd` for one cycle. Every flag bit clears on that read, except a bit whose event rises in the same cycle. Each interrupt line is driven by its own channel state machine. The states are IDLE, SINGLE, TRAIN_HI and TRAIN_LO. The transitions are:
- IDLE goes to SINGLE on an enabled edge when the channel is in single mode.
- IDLE goes to TRAIN_HI on an enabled edge when the channel is in train mode.
- SINGLE returns to IDLE when its width count expires.
- TRAIN_HI and TRAIN_LO alternate each time the half-period count expires.
- Either train state goes to IDLE on a read.
- An enabled edge in any state re-enters SINGLE or TRAIN_HI with a fresh count.

Top module: `evt_irq_pulser`

## Requirements
- R1: During and immediately after reset, both interrupt lines are low and all flag bits are 0.
- R2: A rising edge on `evt_in[i]` sets `flag_q[i]` on the following cycle. The bit then stays set whatever the input does, until a read.
- R3: A one-cycle `flag_rd` clears every flag bit on the next cycle, except a bit whose event rises in that same cycle, which reads back as 1.
- R4: An edge on an event whose bit is 1 in a channel's mask drives that line high on the next cycle. An edge on an event whose mask bit is 0 leaves the line unchanged but still sets its flag.
- R5: With the mode input at 0 (single mode), the line stays high for exactly PULSE_CYC cycles and then falls. A `flag_rd` during the pulse does not shorten it.
- R6: With the mode input at 1 (train mode), the line is high for HALF_CYC cycles, then low for HALF_CYC cycles, and repeats.
- R7: A `flag_rd` while a channel is in train mode drives its line low on the next cycle, and the line stays low until a new enabled edge.
- R8: An enabled edge in the same cycle as `flag_rd` leaves its flag set and restarts the train with a full high phase.
- R9: An enabled edge while a line is already active restarts its count, so a single pulse is extended to PULSE_CYC cycles from the new edge.
- R10: The two channels use separate masks and modes, and one event can drive both lines at the same time.
- R11: An event input held high produces only one trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | NUM_EVT | Event level inputs; a rising edge is an event |
| int1_mask | input | NUM_EVT | Event enables for line 1 |
| int2_mask | input | NUM_EVT | Event enables for line 2 |
| int1_train | input | 1 | Line 1 mode: 0 single pulse, 1 pulse train |
| int2_train | input | 1 | Line 2 mode: 0 single pulse, 1 pulse train |
| flag_rd | input | 1 | One-cycle host read of the flag register |
| flag_q | output | NUM_EVT | Sticky event flags |
| int1_o | output | 1 | Interrupt line 1 |
| int2_o | output | 1 | Interrupt line 2 |

## Verification
Two functions can fall in the same cycle: the clearing read and a fresh enabled event edge. The bench provokes this by pulsing `flag_rd` in the same cycle that a new event bit rises, while one channel is mid-train. It then judges three things:
- the rising bit is the only flag left set;
- the channel whose mask excludes the new bit falls low;
- the other channel holds a full high phase counted from the read cycle, not from its old phase.

A second overlap, a read during a single pulse, is judged by the pulse keeping its full width.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    typedef enum logic [1:0] {
        CH_IDLE     = 2'd0,
        CH_SINGLE   = 2'd1,
        CH_TRAIN_HI = 2'd2,
        CH_TRAIN_LO = 2'd3
    } ch_state_t;

    localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
    parameter int unsigned NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               rd_i,
    output logic [NUM_EVT-1:0] rise_o,
    output logic [NUM_EVT-1:0] flag_o
);
    logic [NUM_EVT-1:0] prev_q;
    logic [NUM_EVT-1:0] flag_q;

    // edge detector: one strobe per low-to-high transition
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= evt_i;
    end

    always_comb rise_o = evt_i & ~prev_q;

    // sticky flags; a read clears, a same-cycle edge survives
    always_ff @(posedge clk) begin
        if (!rst_n)    flag_q <= '0;
        else if (rd_i) flag_q <= rise_o;
        else           flag_q <= flag_q | rise_o;
    end

    always_comb flag_o = flag_q;

    // R2
    flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_o) |=> ((flag_o & $past(rise_o)) == $past(rise_o)));

    // R3
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && (rise_o == '0)) |=> (flag_o == '0));
endmodule

// File: rtl/irq_channel.sv
module irq_channel
    import evt_irq_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 12,
    parameter int unsigned HALF_CYC  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic train_i,
    input  logic rd_i,
    output logic irq_o
);
    localparam int unsigned MAXC = (PULSE_CYC > HALF_CYC) ? PULSE_CYC : HALF_CYC;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] HALF_LAST  = CW'(HALF_CYC - 1);

    ch_state_t     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            CH_IDLE: begin
                cnt_d = '0;
            end
            CH_SINGLE: begin
                if (cnt_q == PULSE_LAST) begin
                    st_d  = CH_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            CH_TRAIN_HI: begin
                if (rd_i) begin
                    st_d  = CH_IDLE;
                    cnt_d = '0;
                end else if (cnt_q == HALF_LAST) begin
                    st_d  = CH_TRAIN_LO;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            CH_TRAIN_LO: begin
                if (rd_i) begin
                    st_d  = CH_IDLE;
                    cnt_d = '0;
                end else if (cnt_q == HALF_LAST) begin
                    st_d  = CH_TRAIN_HI;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                st_d  = CH_IDLE;
                cnt_d = '0;
            end
        endcase
        if (trig_i) begin
            st_d  = train_i ? CH_TRAIN_HI : CH_SINGLE;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CH_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb irq_o = (st_q == CH_SINGLE) || (st_q == CH_TRAIN_HI);

    // R4
    trig_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> irq_o);

    // R4
    quiet_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_IDLE && !trig_i) |=> !irq_o);

    // R7
    read_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == CH_TRAIN_HI || st_q == CH_TRAIN_LO) && rd_i && !trig_i) |=> !irq_o);

    // R5
    single_ignores_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_SINGLE && cnt_q != PULSE_LAST && rd_i) |=> irq_o);
endmodule

// File: rtl/evt_irq_pulser.sv
module evt_irq_pulser
    import evt_irq_pkg::*;
#(
    parameter int unsigned NUM_EVT   = 4,
    parameter int unsigned PULSE_CYC = 12,
    parameter int unsigned HALF_CYC  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [NUM_EVT-1:0] int1_mask,
    input  logic [NUM_EVT-1:0] int2_mask,
    input  logic               int1_train,
    input  logic               int2_train,
    input  logic               flag_rd,
    output logic [NUM_EVT-1:0] flag_q,
    output logic               int1_o,
    output logic               int2_o
);
    logic [NUM_EVT-1:0] rise;
    logic [NUM_EVT-1:0] mask_a [NUM_CH];
    logic               mode_a [NUM_CH];
    logic               irq_a  [NUM_CH];

    always_comb begin
        mask_a[0] = int1_mask;
        mask_a[1] = int2_mask;
        mode_a[0] = int1_train;
        mode_a[1] = int2_train;
    end

    evt_flag_bank #(.NUM_EVT(NUM_EVT)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_in),
        .rd_i   (flag_rd),
        .rise_o (rise),
        .flag_o (flag_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic trig;
        always_comb trig = |(rise & mask_a[c]);

        irq_channel #(.PULSE_CYC(PULSE_CYC), .HALF_CYC(HALF_CYC)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .trig_i  (trig),
            .train_i (mode_a[c]),
            .rd_i    (flag_rd),
            .irq_o   (irq_a[c])
        );
    end

    always_comb begin
        int1_o = irq_a[0];
        int2_o = irq_a[1];
    end
endmodule

// File: tb/evt_irq_pulser_bench.sv
module evt_irq_pulser_bench;
    localparam int NE = 4;

    typedef struct packed {
        logic [3:0] evt;
        logic       rd;
        logic [3:0] m1;
        logic [3:0] m2;
        logic       t1;
        logic       t2;
        logic [7:0] wait_n;
        logic [3:0] xf;
        logic       x1;
        logic       x2;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{4'b0001, 1'b0, 4'b0011, 4'b0100, 1'b0, 1'b1, 8'd1,  4'b0001, 1'b1, 1'b0, 8'd4},  // R4 bit0 enabled on line 1 only
        '{4'b0001, 1'b0, 4'b0011, 4'b0100, 1'b0, 1'b1, 8'd11, 4'b0001, 1'b1, 1'b0, 8'd5},  // R5 still high after 12 cycles
        '{4'b0001, 1'b0, 4'b0011, 4'b0100, 1'b0, 1'b1, 8'd1,  4'b0001, 1'b0, 1'b0, 8'd11}, // R11 held level, no retrigger; R5 falls
        '{4'b0100, 1'b0, 4'b0011, 4'b0100, 1'b0, 1'b1, 8'd1,  4'b0101, 1'b0, 1'b1, 8'd4},  // R4 masked on line 1, train on line 2
        '{4'b0100, 1'b0, 4'b0011, 4'b0100, 1'b0, 1'b1, 8'd5,  4'b0101, 1'b0, 1'b1, 8'd6},  // R6 end of high phase
        '{4'b0100, 1'b0, 4'b0011, 4'b0100, 1'b0, 1'b1, 8'd1,  4'b0101, 1'b0, 1'b0, 8'd6},  // R6 low phase
        '{4'b0100, 1'b0, 4'b0011, 4'b0100, 1'b0, 1'b1, 8'd6,  4'b0101, 1'b0, 1'b1, 8'd6},  // R6 second high phase
        '{4'b0100, 1'b1, 4'b0011, 4'b0100, 1'b0, 1'b1, 8'd1,  4'b0000, 1'b0, 1'b0, 8'd7},  // R7 read stops the train
        '{4'b0100, 1'b0, 4'b0011, 4'b0100, 1'b0, 1'b1, 8'd14, 4'b0000, 1'b0, 1'b0, 8'd7},  // R7 stays low
        '{4'b0000, 1'b0, 4'b0011, 4'b0100, 1'b0, 1'b1, 8'd1,  4'b0000, 1'b0, 1'b0, 8'd2},  // R2 a falling edge sets nothing
        '{4'b1000, 1'b0, 4'b1000, 4'b1000, 1'b1, 1'b1, 8'd3,  4'b1000, 1'b1, 1'b1, 8'd10}, // R10 one event drives both lines
        '{4'b1010, 1'b1, 4'b1000, 4'b1010, 1'b1, 1'b1, 8'd1,  4'b0010, 1'b0, 1'b1, 8'd8},  // R8 edge during read
        '{4'b1010, 1'b0, 4'b1000, 4'b1010, 1'b1, 1'b1, 8'd5,  4'b0010, 1'b0, 1'b1, 8'd8},  // R8 full high phase from restart
        '{4'b1010, 1'b0, 4'b1000, 4'b1010, 1'b1, 1'b1, 8'd1,  4'b0010, 1'b0, 1'b0, 8'd8},  // R8 falls on the new phase
        '{4'b1010, 1'b1, 4'b1000, 4'b1010, 1'b1, 1'b1, 8'd1,  4'b0000, 1'b0, 1'b0, 8'd3},  // R3 plain read clears
        '{4'b0000, 1'b0, 4'b0001, 4'b0000, 1'b0, 1'b0, 8'd1,  4'b0000, 1'b0, 1'b0, 8'd3},  // R3 stays clear
        '{4'b0001, 1'b0, 4'b0001, 4'b0000, 1'b0, 1'b0, 8'd8,  4'b0001, 1'b1, 1'b0, 8'd9},  // R9 first pulse running
        '{4'b0000, 1'b1, 4'b0001, 4'b0000, 1'b0, 1'b0, 8'd1,  4'b0000, 1'b1, 1'b0, 8'd5},  // R5 read does not cut a single pulse
        '{4'b0001, 1'b0, 4'b0001, 4'b0000, 1'b0, 1'b0, 8'd1,  4'b0001, 1'b1, 1'b0, 8'd9},  // R9 retrigger
        '{4'b0001, 1'b0, 4'b0001, 4'b0000, 1'b0, 1'b0, 8'd11, 4'b0001, 1'b1, 1'b0, 8'd9},  // R9 extended pulse
        '{4'b0001, 1'b0, 4'b0001, 4'b0000, 1'b0, 1'b0, 8'd1,  4'b0001, 1'b0, 1'b0, 8'd9}   // R9 ends 12 cycles after retrigger
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt_in = '0;
    logic [NE-1:0] int1_mask = '0;
    logic [NE-1:0] int2_mask = '0;
    logic          int1_train = 1'b0;
    logic          int2_train = 1'b0;
    logic          flag_rd = 1'b0;
    logic [NE-1:0] flag_q;
    logic          int1_o;
    logic          int2_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    evt_irq_pulser #(.NUM_EVT(NE), .PULSE_CYC(12), .HALF_CYC(6)) u_evt_irq_pulser (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_in     (evt_in),
        .int1_mask  (int1_mask),
        .int2_mask  (int2_mask),
        .int1_train (int1_train),
        .int2_train (int2_train),
        .flag_rd    (flag_rd),
        .flag_q     (flag_q),
        .int1_o     (int1_o),
        .int2_o     (int2_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin
        #3000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 state while reset is held
        check("R1", "flags in reset", int'(flag_q), 0);
        check("R1", "int1 in reset", int'(int1_o), 0);
        check("R1", "int2 in reset", int'(int2_o), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "int1 after reset", int'(int1_o), 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            evt_in     = VECS[i].evt;
            flag_rd    = VECS[i].rd;
            int1_mask  = VECS[i].m1;
            int2_mask  = VECS[i].m2;
            int1_train = VECS[i].t1;
            int2_train = VECS[i].t2;
            @(posedge clk);
            @(negedge clk);
            flag_rd = 1'b0;
            for (int w = 1; w < int'(VECS[i].wait_n); w++) begin
                @(posedge clk);
                @(negedge clk);
            end
            check(tag, $sformatf("row %0d flags", i), int'(flag_q), int'(VECS[i].xf));
            check(tag, $sformatf("row %0d int1", i), int'(int1_o), int'(VECS[i].x1));
            check(tag, $sformatf("row %0d int2", i), int'(int2_o), int'(VECS[i].x2));
        end

        // R1 reset in the middle of an active train
        evt_in = '0;
        int1_mask = 4'b0100;
        int1_train = 1'b1;
        @(posedge clk);
        @(negedge clk);
        evt_in = 4'b0100;
        @(posedge clk);
        @(negedge clk);
        check("R1", "int1 active before reset", int'(int1_o), 1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", "int1 after mid-run reset", int'(int1_o), 0);
        check("R1", "flags after mid-run reset", int'(flag_q), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R11 level still high after reset: edge history is cleared, so it counts once
        check("R11", "flag after reset with level high", int'(flag_q), 4'b0100);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule